// File: doc/BRIEF.md
# Multi-Frame SPI Master Engine

This block is a synchronous serial master. It drives the serial clock and one active-low slave select. It shifts transmit data out on MOSI and captures MISO into a receive image. A host hands over a 128-bit transmit image together with a frame count through a valid/ready port. The engine then runs one select-framed sequence of one to four frames, back to back. The bit count per frame, the shift order, the clock polarity and phase, and the clock divider are all sampled from the configuration inputs at the moment a sequence starts.

Each direction has two stages. The transmit side has a holding register and a shifting register, so the next image can be accepted while the current one is on the wire. The receive side assembles the incoming frames internally and then moves the finished image into a holding register that the host drains. If that holding register is still unread when a new sequence is about to complete, the engine parks the serial clock in front of the final sampling edge. It resumes only once the host takes the old image, so received data is never overwritten.

Top module: `spib_master`

## Requirements
- R1: During reset and directly after it, ss_n is 1, busy, done and rx_valid are 0, tx_ready is 1 and sck is 0.
- R2: cfg_len_code selects the bits per frame. Codes 0 to 8 give 8 to 16 bits (8 + code), code 9 gives 20, code 10 gives 24, and codes 11 to 15 give 32.
- R3: Frame 0 goes on the wire first. Frame f occupies bits [32f+L-1 : 32f] of tx_data, where L is the frame length. With cfg_lsb_first = 0 the bit at 32f+L-1 leaves first; with 1 the bit at 32f leaves first.
- R4: While idle, sck rests at cfg_cpol. With cfg_cpha = 0 both sides sample on the first edge of each bit and change data on the second; with cfg_cpha = 1 data changes on the first edge and is sampled on the second.
- R5: Each sck half-period lasts cfg_div + 1 system clocks.
- R6: ss_n falls cfg_div + 1 clocks before the first sck edge and rises cfg_div + 1 clocks after the last sck edge.
- R7: A sequence carries tx_nfrm + 1 frames, from 1 to 4.
- R8: rx_data places frame f right-aligned in bits [32f+31 : 32f], zero-extended, using the same bit order as transmit. Slots beyond the frame count read as zero.
- R9: tx_ready is high whenever the transmit holding stage is empty. An image accepted during a running sequence starts only after ss_n has returned high.
- R10: While rx_valid is 1 and rx_ready is 0, a sequence that reaches its final sampling edge holds sck still, with ss_n low and busy high. rx_data stays unchanged until the host takes it.
- R11: done is a one-clock pulse in the cycle ss_n rises at the end of a sequence. busy is high from the clock after acceptance by the engine through that done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_cpha | input | 1 | Sampling phase: 0 samples on the first edge of a bit |
| cfg_lsb_first | input | 1 | 1 sends and receives the lowest frame bit first |
| cfg_len_code | input | 4 | Frame length code (see R2) |
| cfg_div | input | DIV_W | Half-period of sck minus one, in clocks |
| tx_valid | input | 1 | Transmit image offered |
| tx_ready | output | 1 | Transmit holding stage empty |
| tx_data | input | 128 | Transmit image, four 32-bit slots |
| tx_nfrm | input | 2 | Frame count minus one |
| rx_valid | output | 1 | Receive image held for the host |
| rx_ready | input | 1 | Host takes the receive image |
| rx_data | output | 128 | Receive image, four 32-bit slots |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | End-of-sequence pulse |

## Verification
Several properties are checked on every cycle. The select stays high while the engine is idle. The done pulse lasts one cycle and finds the select high and sck at its idle level. The divider count stays within bounds. A pending transmit image is never dropped. No receive capture happens while the held image is unread, and that image stays stable until it is taken. The bench scenarios are the only evidence for the bit-level outcomes: the order and length of the frames on the wire for each length code, shift order and clock mode; the alignment of the received frames; the lead, trail and half-period timing; the hand-over of two queued images; and the parked clock while the receive stage is full.

// File: rtl/spib_pkg.sv
package spib_pkg;

   localparam int SLOT_W = 32;
   localparam int LEN_W  = 6;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_SHIFT = 2'd1,
      SQ_TRAIL = 2'd2
   } sq_state_t;

   // R2: length code to bits per frame
   function automatic logic [LEN_W-1:0] code_to_len(input logic [3:0] code);
      logic [LEN_W-1:0] n;
      case (code)
         4'd9:    n = 6'd20;
         4'd10:   n = 6'd24;
         default: n = (code <= 4'd8) ? (6'd8 + {2'b00, code}) : 6'd32;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/spib_clkdiv.sv
module spib_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && !hold && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run || tick)     cnt_q <= '0;
      else if (cnt_q != div)     cnt_q <= cnt_q + 1'b1;
   end

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= div));

   // R10
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && hold && cnt_q == div) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/spib_txbuf.sv
module spib_txbuf #(
   parameter int BUF_W = 128,
   parameter int NF_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_valid,
   output logic             push_ready,
   input  logic [BUF_W-1:0] push_data,
   input  logic [NF_W-1:0]  push_nf,
   input  logic             load,
   output logic             pend_v,
   output logic [NF_W-1:0]  pend_nf,
   output logic [BUF_W-1:0] act_data
);

   logic [BUF_W-1:0] pend_data;

   assign push_ready = !pend_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_nf   <= '0;
         pend_data <= '0;
         act_data  <= '0;
      end else begin
         if (push_valid && push_ready) begin
            pend_v    <= 1'b1;
            pend_nf   <= push_nf;
            pend_data <= push_data;
         end else if (load) begin
            pend_v    <= 1'b0;
         end
         if (load) act_data <= pend_data;
      end
   end

   // R9
   pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v && !load) |=> pend_v);

   // R9
   load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> pend_v);

endmodule

// File: rtl/spib_rxbuf.sv
module spib_rxbuf #(
   parameter int BUF_W = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [BUF_W-1:0] cap_data,
   input  logic             pop_ready,
   output logic             hold_valid,
   output logic [BUF_W-1:0] hold_data,
   output logic             full
);

   assign full = hold_valid && !pop_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_data  <= '0;
      end else if (cap) begin
         hold_valid <= 1'b1;
         hold_data  <= cap_data;
      end else if (hold_valid && pop_ready) begin
         hold_valid <= 1'b0;
      end
   end

   // R10
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_valid && !pop_ready) |=> (hold_valid && $stable(hold_data)));

endmodule

// File: rtl/spib_master.sv
module spib_master
   import spib_pkg::*;
#(
   parameter int MAX_FRAMES = 4,
   parameter int DIV_W      = 8,
   localparam int NF_W      = $clog2(MAX_FRAMES),
   localparam int BUF_W     = MAX_FRAMES * SLOT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_cpol,
   input  logic             cfg_cpha,
   input  logic             cfg_lsb_first,
   input  logic [3:0]       cfg_len_code,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             tx_valid,
   output logic             tx_ready,
   input  logic [BUF_W-1:0] tx_data,
   input  logic [NF_W-1:0]  tx_nfrm,
   output logic             rx_valid,
   input  logic             rx_ready,
   output logic [BUF_W-1:0] rx_data,
   output logic             sck,
   output logic             mosi,
   input  logic             miso,
   output logic             ss_n,
   output logic             busy,
   output logic             done
);

   localparam int POS_W = $clog2(SLOT_W);
   localparam int IDX_W = NF_W + POS_W;

   if (MAX_FRAMES < 2 || (MAX_FRAMES & (MAX_FRAMES - 1)) != 0) begin : g_bad_frames
      $error("MAX_FRAMES must be a power of two of at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   sq_state_t        state_q;
   logic             ss_q, sck_q, done_q;
   logic             cpol_q, cpha_q, lsb_q;
   logic [LEN_W-1:0] len_q;
   logic [DIV_W-1:0] div_q;
   logic [NF_W-1:0]  nf_q, df_q, sf_q;
   logic [POS_W-1:0] db_q, sb_q;
   logic             ph_q, first_q, last_q;

   logic             pend_v, load, tick, rx_full, rx_cap;
   logic [NF_W-1:0]  pend_nf;
   logic [BUF_W-1:0] act_data, asm_w, rx_merge;
   logic [LEN_W-1:0] len_m1;
   logic [POS_W-1:0] lm1, dpos, spos;
   logic [IDX_W-1:0] didx, sidx;
   logic             smp_edge, fin_smp, stall;

   assign load     = (state_q == SQ_IDLE) && pend_v;
   assign len_m1   = len_q - 1'b1;
   assign lm1      = len_m1[POS_W-1:0];
   assign dpos     = lsb_q ? db_q : (lm1 - db_q);
   assign spos     = lsb_q ? sb_q : (lm1 - sb_q);
   assign didx     = {df_q, dpos};
   assign sidx     = {sf_q, spos};
   assign smp_edge = ph_q ^ ~cpha_q;
   assign fin_smp  = smp_edge && (sf_q == nf_q) && (sb_q == lm1);
   assign stall    = (state_q == SQ_SHIFT) && fin_smp && rx_full;
   assign rx_cap   = (state_q == SQ_SHIFT) && tick && fin_smp;

   assign sck  = sck_q;
   assign ss_n = ss_q;
   assign done = done_q;
   assign busy = (state_q != SQ_IDLE) || done_q;
   assign mosi = (state_q != SQ_IDLE) ? act_data[didx] : 1'b0;

   spib_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(state_q != SQ_IDLE), .hold(stall),
      .div(div_q), .tick(tick)
   );

   spib_txbuf #(.BUF_W(BUF_W), .NF_W(NF_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .push_valid(tx_valid), .push_ready(tx_ready),
      .push_data(tx_data), .push_nf(tx_nfrm), .load(load), .pend_v(pend_v),
      .pend_nf(pend_nf), .act_data(act_data)
   );

   spib_rxbuf #(.BUF_W(BUF_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .cap(rx_cap), .cap_data(rx_merge),
      .pop_ready(rx_ready), .hold_valid(rx_valid), .hold_data(rx_data),
      .full(rx_full)
   );

   // receive assembly, one slot per frame
   for (genvar i = 0; i < MAX_FRAMES; i++) begin : g_slot
      logic [SLOT_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (load)
            slot_q <= '0;
         else if (state_q == SQ_SHIFT && tick && smp_edge && sf_q == NF_W'(i))
            slot_q[spos] <= miso;
      end
      assign asm_w[i*SLOT_W +: SLOT_W] = slot_q;
   end

   always_comb begin
      rx_merge       = asm_w;
      rx_merge[sidx] = miso;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         ss_q    <= 1'b1;
         sck_q   <= 1'b0;
         done_q  <= 1'b0;
         cpol_q  <= 1'b0;
         cpha_q  <= 1'b0;
         lsb_q   <= 1'b0;
         len_q   <= LEN_W'(8);
         div_q   <= '0;
         nf_q    <= '0;
         df_q    <= '0;
         sf_q    <= '0;
         db_q    <= '0;
         sb_q    <= '0;
         ph_q    <= 1'b0;
         first_q <= 1'b0;
         last_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               sck_q <= cfg_cpol;
               if (pend_v) begin
                  state_q <= SQ_SHIFT;
                  ss_q    <= 1'b0;
                  cpol_q  <= cfg_cpol;
                  cpha_q  <= cfg_cpha;
                  lsb_q   <= cfg_lsb_first;
                  len_q   <= code_to_len(cfg_len_code);
                  div_q   <= cfg_div;
                  nf_q    <= pend_nf;
                  df_q    <= '0;
                  sf_q    <= '0;
                  db_q    <= '0;
                  sb_q    <= '0;
                  ph_q    <= 1'b0;
                  first_q <= 1'b1;
                  last_q  <= 1'b0;
               end
            end
            SQ_SHIFT: begin
               if (tick) begin
                  sck_q   <= ~sck_q;
                  ph_q    <= ~ph_q;
                  first_q <= 1'b0;
                  if (smp_edge) begin
                     if (sb_q == lm1) begin
                        sb_q <= '0;
                        sf_q <= sf_q + 1'b1;
                     end else begin
                        sb_q <= sb_q + 1'b1;
                     end
                     if (fin_smp) begin
                        if (cpha_q) state_q <= SQ_TRAIL;
                        else        last_q  <= 1'b1;
                     end
                  end else begin
                     if (!first_q) begin
                        if (db_q == lm1) begin
                           db_q <= '0;
                           df_q <= df_q + 1'b1;
                        end else begin
                           db_q <= db_q + 1'b1;
                        end
                     end
                     if (last_q) state_q <= SQ_TRAIL;
                  end
               end
            end
            SQ_TRAIL: begin
               if (tick) begin
                  state_q <= SQ_IDLE;
                  ss_q    <= 1'b1;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ss_n && sck == cpol_q));

   // R6
   ss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ss_n);

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cap |-> !rx_full);

endmodule

// File: tb/spib_master_test.sv
`timescale 1ns/1ps
module spib_master_test;

   localparam int CLK_NS = 4;

   typedef struct {
      logic [127:0] img;
      logic [127:0] reply;
      int           nf;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
   logic [3:0]   cfg_len_code = 4'd0;
   logic [7:0]   cfg_div = 8'd0;
   logic         tx_valid = 1'b0;
   logic         tx_ready;
   logic [127:0] tx_data = '0;
   logic [1:0]   tx_nfrm = 2'd0;
   logic         rx_valid;
   logic         rx_ready = 1'b1;
   logic [127:0] rx_data;
   logic         sck, mosi, ss_n, busy, done;
   logic         miso = 1'b0;

   item_t        slv_q[$];
   logic [127:0] rx_q[$];
   int           checks = 0, errors = 0, ndone = 0;
   logic         prev_done = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   spib_master uut (
      .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_lsb_first(cfg_lsb_first), .cfg_len_code(cfg_len_code), .cfg_div(cfg_div),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_nfrm(tx_nfrm),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n), .busy(busy), .done(done)
   );

   function automatic int len_of(input logic [3:0] c);
      if (c <= 4'd8) return 8 + int'(c);
      if (c == 4'd9) return 20;
      if (c == 4'd10) return 24;
      return 32;
   endfunction

   function automatic logic [127:0] keep(input logic [127:0] v, input int nf, input int len);
      logic [127:0] r;
      r = '0;
      for (int f = 0; f <= nf; f++)
         for (int b = 0; b < len; b++)
            r[f*32+b] = v[f*32+b];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic lead_e();
      if (cfg_cpol) @(negedge sck); else @(posedge sck);
   endtask

   task automatic trail_e();
      if (cfg_cpol) @(posedge sck); else @(negedge sck);
   endtask

   // slave model and wire-side monitor
   initial begin : slave
      forever begin
         item_t        it;
         int           len, idx, hp;
         logic [127:0] got, want;
         time          t0, t1, t2, tl;
         @(negedge ss_n);
         t0 = $time;
         t1 = 0;
         t2 = 0;
         if (slv_q.size() == 0) begin
            chk(1'b0, "R9 select without queued image", 0, 0);
            continue;
         end
         it  = slv_q.pop_front();
         len = len_of(cfg_len_code);
         hp  = (int'(cfg_div) + 1) * CLK_NS;
         got = '0;
         for (int f = 0; f <= it.nf; f++) begin
            for (int b = 0; b < len; b++) begin
               idx = f*32 + (cfg_lsb_first ? b : len - 1 - b);
               if (!cfg_cpha) begin
                  miso = it.reply[idx];
                  lead_e();
                  if (f == 0 && b == 0) t1 = $time;
                  got[idx] = mosi;
                  trail_e();
                  if (f == 0 && b == 0) t2 = $time;
               end else begin
                  lead_e();
                  if (f == 0 && b == 0) t1 = $time;
                  miso = it.reply[idx];
                  trail_e();
                  if (f == 0 && b == 0) t2 = $time;
                  got[idx] = mosi;
               end
            end
         end
         tl = $time;
         @(posedge ss_n);
         want = keep(it.img, it.nf, len);
         // R2 R3 R4 R7: frames on the wire
         chk(got == want, "R3 wire frames (R2 R4 R7)", got, want);
         chk((t1 - t0) == time'(hp), "R6 select lead", t1 - t0, hp);
         chk((t2 - t1) == time'(hp), "R5 half period", t2 - t1, hp);
         chk(($time - tl) == time'(hp), "R6 select trail", $time - tl, hp);
      end
   end

   // scoreboard monitor on the host side
   initial begin : host_mon
      forever begin
         logic [127:0] e;
         @(negedge clk);
         if (rst_n && rx_valid && rx_ready) begin
            if (rx_q.size() == 0) chk(1'b0, "R8 unexpected receive image", rx_data, 0);
            else begin
               e = rx_q.pop_front();
               chk(rx_data == e, "R8 receive image", rx_data, e);
            end
         end
         if (rst_n && done) begin
            ndone++;
            chk(ss_n && busy, "R11 done with ss_n high and busy", {ss_n, busy}, 2'b11);
            chk(!prev_done, "R11 done single cycle", prev_done, 0);
         end
         prev_done = done;
      end
   end

   task automatic set_cfg(input bit pol, input bit pha, input bit lsb, input logic [3:0] code, input logic [7:0] dv);
      @(posedge clk); #1;
      cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb;
      cfg_len_code = code; cfg_div = dv;
   endtask

   task automatic push(input int nf, input logic [127:0] img, input logic [127:0] rep, output bit busy_at);
      item_t it;
      it.img = img; it.reply = rep; it.nf = nf;
      slv_q.push_back(it);
      rx_q.push_back(keep(rep, nf, len_of(cfg_len_code)));
      @(posedge clk); #1;
      tx_data = img; tx_nfrm = nf[1:0]; tx_valid = 1'b1;
      do @(posedge clk); while (!tx_ready);
      busy_at = busy;
      #1 tx_valid = 1'b0;
   endtask

   task automatic wait_quiet();
      int n;
      n = 0;
      while ((busy || slv_q.size() != 0 || rx_q.size() != 0 || rx_valid) && n < 20000) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk);
   endtask

   task automatic one(input bit pol, input bit pha, input bit lsb, input logic [3:0] code,
                      input logic [7:0] dv, input int nf, input logic [127:0] img, input logic [127:0] rep);
      bit b;
      int n0;
      n0 = ndone;
      set_cfg(pol, pha, lsb, code, dv);
      repeat (2) @(negedge clk);
      chk(sck == pol, "R4 idle sck level", sck, pol);
      push(nf, img, rep, b);
      wait_quiet();
      chk(ndone == n0 + 1, "R11 one done per sequence", ndone, n0 + 1);
   endtask

   initial begin : watchdog
      #(200000 * CLK_NS);
      chk(1'b0, "R11 watchdog expired", 0, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      bit b0, b1;
      int n0, changes;
      logic s_prev;
      repeat (3) @(negedge clk);
      // R1
      chk(ss_n && !busy && !done && !rx_valid && tx_ready && !sck, "R1 reset state",
          {ss_n, busy, done, rx_valid, tx_ready, sck}, 6'b100010);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(ss_n && !busy && tx_ready && !sck, "R1 after release", {ss_n, busy, tx_ready, sck}, 4'b1010);

      one(0, 0, 0, 4'd0,  8'd1, 0, 128'h0000_0000_0000_0000_0000_0000_DEAD_BEA5,
                                   128'h0000_0000_0000_0000_0000_0000_1234_563C);
      one(1, 1, 1, 4'd8,  8'd0, 3, 128'h1111_A5C3_2222_0F1E_3333_8001_4444_7E42,
                                   128'hFFFF_3C5A_EEEE_9001_DDDD_0FF0_CCCC_8124);
      one(0, 1, 0, 4'd9,  8'd2, 1, 128'h0000_0000_0000_0000_ABCD_E123_FF05_A5A5,
                                   128'h0000_0000_0000_0000_5555_3C3C_0A0B_C0DE);
      one(1, 0, 1, 4'd10, 8'd1, 2, 128'hAAAA_AAAA_1234_5678_9ABC_DEF0_0F0F_1E2D,
                                   128'h5555_5555_8765_4321_F0E1_D2C3_00B4_A596);
      one(0, 0, 0, 4'd11, 8'd0, 3, 128'h8000_0001_C3A5_5A3C_0123_4567_FEDC_BA98,
                                   128'h7FFF_FFFE_1357_9BDF_2468_ACE0_8421_1248);
      one(0, 1, 1, 4'd5,  8'd3, 2, 128'hFFFF_FFFF_0000_1ABC_0000_0D05_0000_1F2E,
                                   128'h0000_0000_0000_0A5A_0000_1FFF_0000_15C3);

      // R9: second image accepted while the first one shifts
      n0 = ndone;
      set_cfg(0, 0, 0, 4'd2, 8'd0);
      push(1, 128'h0000_0000_0000_0000_0000_02A5_0000_0133,
              128'h0000_0000_0000_0000_0000_0111_0000_03C0, b0);
      push(0, 128'h0000_0000_0000_0000_0000_0000_0000_0355,
              128'h0000_0000_0000_0000_0000_0000_0000_00AA, b1);
      chk(b1, "R9 second image accepted while busy", b1, 1);
      wait_quiet();
      chk(ndone == n0 + 2, "R9 two sequences completed", ndone, n0 + 2);

      // R10: receive stage full parks the clock
      n0 = ndone;
      set_cfg(1, 1, 1, 4'd4, 8'd1);
      @(posedge clk); #1 rx_ready = 1'b0;
      push(0, 128'h0000_0000_0000_0000_0000_0000_0000_0ABC,
              128'h0000_0000_0000_0000_0000_0000_0000_0F0F, b0);
      push(0, 128'h0000_0000_0000_0000_0000_0000_0000_0531,
              128'h0000_0000_0000_0000_0000_0000_0000_0A66, b1);
      repeat (300) @(negedge clk);
      changes = 0;
      s_prev = sck;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (sck != s_prev) changes++;
         s_prev = sck;
      end
      chk(changes == 0, "R10 sck parked while receive full", changes, 0);
      chk(busy && !ss_n, "R10 sequence held open", {busy, ss_n}, 2'b10);
      chk(ndone == n0 + 1, "R10 only first sequence done", ndone, n0 + 1);
      chk(rx_valid && rx_data == rx_q[0], "R10 held image unchanged", rx_data, rx_q[0]);
      @(posedge clk); #1 rx_ready = 1'b1;
      wait_quiet();
      chk(ndone == n0 + 2, "R10 sequence resumes after read", ndone, n0 + 2);

      chk(slv_q.size() == 0 && rx_q.size() == 0, "R8 scoreboard drained",
          slv_q.size() + rx_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule